// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control state machine for a memory that has a working array and a nonvolatile shadow array behind it. It moves data between the two arrays on three occasions: when a STORE is commanded, when a RECALL is commanded, and on its own when the supply-good flag first goes high after reset. Each transfer runs in two timed phases. A store first erases the shadow and then programs it from the working array. A recall first wipes the working array and then loads it from the shadow. A counter times every phase, and parameters set the cycle counts for store, recall and power-up restore.

While a transfer runs, the block reports busy and ignores all access traffic and commands. Read data stays at zero during that time. Only the idle state reports ready, so no write can land while the power-up restore is still running. A store can be cut short by a drop in supply. A recall always runs to completion. The port drives four array strobes, one per transfer step. Small behavioural working and shadow arrays are built in, so the effect of each transfer can be seen through the read port.

Top module: `nvs_sequencer`

## Requirements
- R1: After reset, ready and busy stay low for as long as supply_ok is low. On the first cycle with supply_ok high, a power-up recall starts. Busy then stays high for exactly RESTORE_CYC cycles, and after that ready goes high. At reset, address i of the shadow array holds (37*i+11) mod 256.
- R2: A recall raises wipe_work first and load_work on a later cycle. It leaves every working word equal to the shadow word at the same address, and it does not change the shadow.
- R3: A store raises erase_shadow first and prog_shadow on a later cycle. After it, every shadow word equals the working word at the same address.
- R4: A store_req while supply_ok is low is rejected. Busy stays low and the shadow keeps its contents.
- R5: If supply_ok is low during a store, the store stops. The block returns to ready with store_err set to 1. If the stop comes in the erase phase, the shadow is unchanged. If it comes in the program phase, every shadow word reads back as all ones.
- R6: store_err stays set until a store completes, and a completed store clears it.
- R7: A recall runs its full RECALL_CYC cycles even if supply_ok falls while it runs. In that case, ready stays low after the recall until supply_ok is high again, and then a power-up recall of RESTORE_CYC cycles follows.
- R8: While busy is high, ready is low. Writes have no effect, and acc_rdata reads zero in the cycle after any busy cycle.
- R9: A store_req or recall_req that arrives while busy is high is dropped. No second transfer follows the current one.
- R10: A completed store keeps busy high for exactly STORE_CYC cycles. A commanded recall keeps it high for exactly RECALL_CYC cycles.
- R11: While ready is high, a write (acc_en=1, acc_we=1) updates the addressed word at the clock edge. A read (acc_en=1, acc_we=0) returns the word on acc_rdata one cycle later.
- R12: If store_req and recall_req are both high in a ready cycle, the recall is taken.
- R13: At most one of the four array strobes is high in any cycle, and a strobe is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above the switch threshold |
| store_req | input | 1 | Store command pulse |
| recall_req | input | 1 | Recall command pulse |
| acc_en | input | 1 | Access enable |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | ADDR_W | Word address |
| acc_wdata | input | WIDTH | Write data |
| acc_rdata | output | WIDTH | Registered read data |
| busy | output | 1 | Transfer in progress |
| ready | output | 1 | Normal access allowed |
| store_err | output | 1 | Last store was aborted |
| wipe_work | output | 1 | Strobe: clear working array |
| load_work | output | 1 | Strobe: copy shadow into working array |
| erase_shadow | output | 1 | Strobe: erase shadow array |
| prog_shadow | output | 1 | Strobe: program shadow from working array |

## Verification
The hardest cases to reach are a supply drop that lands inside one chosen phase of a transfer: the program phase of a store, or the middle of a recall that must not be cut short. The bench counts busy cycles from the command and drops supply_ok on a chosen count. Because recall is not subject to the supply check, the bench then runs a recall with supply low. That recall copies the shadow into the working array, so the bench can read the shadow through the normal read port and tell an erase-phase abort apart from a program-phase abort.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        S_WAIT_PWR,
        S_IDLE,
        S_ST_ERASE,
        S_ST_PROG,
        S_RC_CLEAR,
        S_RC_COPY
    } seq_state_e;

    typedef struct packed {
        logic wipe_work;
        logic load_work;
        logic erase_shadow;
        logic prog_shadow;
    } arr_cmd_t;

    function automatic int first_half(input int n);
        return n / 2;
    endfunction

    function automatic int cnt_bits(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

    function automatic logic [31:0] seed_word(input int i);
        return 32'((37 * i + 11) % 256);
    endfunction

endpackage

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int STORE_CYC   = 20,
    parameter int RECALL_CYC  = 8,
    parameter int RESTORE_CYC = 30,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             store_req,
    input  logic             recall_req,
    input  logic             tmr_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output arr_cmd_t         cmd,
    output logic             busy,
    output logic             ready,
    output logic             store_err
);
    localparam int ERASE_LEN  = first_half(STORE_CYC);
    localparam int PROG_LEN   = STORE_CYC - ERASE_LEN;
    localparam int CLR_LEN    = first_half(RECALL_CYC);
    localparam int CPY_LEN    = RECALL_CYC - CLR_LEN;
    localparam int PU_CPY_LEN = RESTORE_CYC - CLR_LEN;

    localparam logic [CNT_W-1:0] ERASE_LD  = CNT_W'(ERASE_LEN - 1);
    localparam logic [CNT_W-1:0] PROG_LD   = CNT_W'(PROG_LEN - 1);
    localparam logic [CNT_W-1:0] CLR_LD    = CNT_W'(CLR_LEN - 1);
    localparam logic [CNT_W-1:0] CPY_LD    = CNT_W'(CPY_LEN - 1);
    localparam logic [CNT_W-1:0] PU_CPY_LD = CNT_W'(PU_CPY_LEN - 1);

    seq_state_e state_q, state_n;
    logic       pu_q, pu_n;
    logic       rearm_q, rearm_n;
    logic       err_q, err_n;
    logic       sup_q;
    logic       sup_fall;

    assign sup_fall = sup_q && !supply_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_WAIT_PWR;
            pu_q    <= 1'b0;
            rearm_q <= 1'b0;
            err_q   <= 1'b0;
            sup_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            pu_q    <= pu_n;
            rearm_q <= rearm_n;
            err_q   <= err_n;
            sup_q   <= supply_ok;
        end
    end

    always_comb begin
        state_n  = state_q;
        pu_n     = pu_q;
        rearm_n  = rearm_q;
        err_n    = err_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cmd      = '0;
        unique case (state_q)
            S_WAIT_PWR: begin
                if (supply_ok) begin
                    state_n  = S_RC_CLEAR;
                    pu_n     = 1'b1;
                    rearm_n  = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CLR_LD;
                end
            end
            S_IDLE: begin
                if (recall_req) begin
                    state_n  = S_RC_CLEAR;
                    pu_n     = 1'b0;
                    rearm_n  = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CLR_LD;
                end else if (store_req && supply_ok) begin
                    state_n  = S_ST_ERASE;
                    tmr_load = 1'b1;
                    tmr_val  = ERASE_LD;
                end
            end
            S_ST_ERASE: begin
                if (!supply_ok) begin
                    state_n = S_IDLE;
                    err_n   = 1'b1;
                end else if (tmr_last) begin
                    cmd.erase_shadow = 1'b1;
                    state_n  = S_ST_PROG;
                    tmr_load = 1'b1;
                    tmr_val  = PROG_LD;
                end
            end
            S_ST_PROG: begin
                if (!supply_ok) begin
                    state_n = S_IDLE;
                    err_n   = 1'b1;
                end else if (tmr_last) begin
                    cmd.prog_shadow = 1'b1;
                    state_n = S_IDLE;
                    err_n   = 1'b0;
                end
            end
            S_RC_CLEAR: begin
                if (sup_fall) begin
                    rearm_n = 1'b1;
                end
                if (tmr_last) begin
                    cmd.wipe_work = 1'b1;
                    state_n  = S_RC_COPY;
                    tmr_load = 1'b1;
                    tmr_val  = pu_q ? PU_CPY_LD : CPY_LD;
                end
            end
            S_RC_COPY: begin
                if (tmr_last) begin
                    cmd.load_work = 1'b1;
                    state_n = (rearm_q || sup_fall) ? S_WAIT_PWR : S_IDLE;
                    rearm_n = 1'b0;
                end else if (sup_fall) begin
                    rearm_n = 1'b1;
                end
            end
            default: state_n = S_WAIT_PWR;
        endcase
    end

    assign busy      = (state_q == S_ST_ERASE) || (state_q == S_ST_PROG) ||
                       (state_q == S_RC_CLEAR) || (state_q == S_RC_COPY);
    assign ready     = (state_q == S_IDLE);
    assign store_err = err_q;
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays
    import nvs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  arr_cmd_t          cmd,
    input  logic              acc_ok,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WIDTH-1:0]  acc_wdata,
    output logic [WIDTH-1:0]  acc_rdata
);
    logic [WIDTH-1:0] work_q   [DEPTH];
    logic [WIDTH-1:0] shadow_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                work_q[i]   <= '0;
                shadow_q[i] <= WIDTH'(seed_word(i));
            end
            acc_rdata <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cmd.wipe_work) begin
                    work_q[i] <= '0;
                end else if (cmd.load_work) begin
                    work_q[i] <= shadow_q[i];
                end else if (acc_ok && acc_we && (acc_addr == ADDR_W'(i))) begin
                    work_q[i] <= acc_wdata;
                end
                if (cmd.erase_shadow) begin
                    shadow_q[i] <= '1;
                end else if (cmd.prog_shadow) begin
                    shadow_q[i] <= work_q[i];
                end
            end
            acc_rdata <= (acc_ok && !acc_we) ? work_q[acc_addr] : '0;
        end
    end
endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
    import nvs_pkg::*;
#(
    parameter int STORE_CYC   = 2000000,
    parameter int RECALL_CYC  = 4000,
    parameter int RESTORE_CYC = 130000,
    parameter int DEPTH       = 16,
    parameter int WIDTH       = 8,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              store_req,
    input  logic              recall_req,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WIDTH-1:0]  acc_wdata,
    output logic [WIDTH-1:0]  acc_rdata,
    output logic              busy,
    output logic              ready,
    output logic              store_err,
    output logic              wipe_work,
    output logic              load_work,
    output logic              erase_shadow,
    output logic              prog_shadow
);
    localparam int CNT_W = cnt_bits(STORE_CYC, RESTORE_CYC);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    arr_cmd_t         cmd;

    nvs_ctrl #(
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC),
        .RESTORE_CYC(RESTORE_CYC),
        .CNT_W      (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .store_req (store_req),
        .recall_req(recall_req),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .cmd       (cmd),
        .busy      (busy),
        .ready     (ready),
        .store_err (store_err)
    );

    nvs_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    nvs_arrays #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) arrays_i (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .acc_ok   (ready && acc_en),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata)
    );

    assign wipe_work    = cmd.wipe_work;
    assign load_work    = cmd.load_work;
    assign erase_shadow = cmd.erase_shadow;
    assign prog_shadow  = cmd.prog_shadow;
endmodule

// File: rtl/nvs_sequencer_chk.sv
module nvs_sequencer_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             supply_ok,
    input logic             store_req,
    input logic             recall_req,
    input logic             busy,
    input logic             ready,
    input logic             store_err,
    input logic [WIDTH-1:0] acc_rdata,
    input logic             wipe_work,
    input logic             load_work,
    input logic             erase_shadow,
    input logic             prog_shadow
);
    logic any_strobe;
    assign any_strobe = wipe_work | load_work | erase_shadow | prog_shadow;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wipe_work, load_work, erase_shadow, prog_shadow})); // R13
    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> busy); // R13
    AST_READY_EXCL_BUSY: assert property (@(posedge clk) disable iff (rst)
        ready |-> !busy); // R8
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy |=> (acc_rdata == '0)); // R8
    AST_STORE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (ready && store_req && !recall_req && !supply_ok) |=> !busy); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (store_err && !prog_shadow) |=> store_err); // R6
    AST_WIPE_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        wipe_work |=> busy); // R7
    AST_ERASE_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (erase_shadow && supply_ok) |=> (busy && !ready)); // R3
    AST_READY_AFTER_OP: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(busy)); // R1
endmodule

bind nvs_sequencer nvs_sequencer_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok),
    .store_req   (store_req),
    .recall_req  (recall_req),
    .busy        (busy),
    .ready       (ready),
    .store_err   (store_err),
    .acc_rdata   (acc_rdata),
    .wipe_work   (wipe_work),
    .load_work   (load_work),
    .erase_shadow(erase_shadow),
    .prog_shadow (prog_shadow)
);

// File: tb/nvs_sequencer_tb_top.sv
`timescale 1ns/1ps
module nvs_sequencer_tb_top;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int ST    = 20;
    localparam int RC    = 8;
    localparam int RS    = 30;

    localparam logic [11:0] VEC [8] = '{
        {4'd0, 8'h3C}, {4'd15, 8'hA5}, {4'd7, 8'h00}, {4'd8, 8'hFF},
        {4'd3, 8'h81}, {4'd12, 8'h5A}, {4'd1, 8'h7E}, {4'd9, 8'hC3}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst, supply_ok, store_req, recall_req;
    logic             acc_en, acc_we;
    logic [3:0]       acc_addr;
    logic [WIDTH-1:0] acc_wdata, acc_rdata;
    logic             busy, ready, store_err;
    logic             wipe_work, load_work, erase_shadow, prog_shadow;

    nvs_sequencer #(
        .STORE_CYC(ST), .RECALL_CYC(RC), .RESTORE_CYC(RS),
        .DEPTH(DEPTH), .WIDTH(WIDTH)
    ) dut_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .store_req(store_req), .recall_req(recall_req),
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .busy(busy), .ready(ready), .store_err(store_err),
        .wipe_work(wipe_work), .load_work(load_work),
        .erase_shadow(erase_shadow), .prog_shadow(prog_shadow)
    );

    int checks = 0;
    int fails  = 0;
    int i_clr, i_cpy, i_era, i_prg;
    int multi_strobe = 0;
    logic [7:0] shad_m [DEPTH];
    logic [7:0] work_m [DEPTH];

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic mark(input int n);
        if (wipe_work    && i_clr < 0) i_clr = n;
        if (load_work    && i_cpy < 0) i_cpy = n;
        if (erase_shadow && i_era < 0) i_era = n;
        if (prog_shadow  && i_prg < 0) i_prg = n;
        if ((32'(wipe_work) + 32'(load_work) + 32'(erase_shadow) + 32'(prog_shadow)) > 1)
            multi_strobe++;
    endtask

    task automatic count_busy(input int drop_at, output int n);
        n = 0; i_clr = -1; i_cpy = -1; i_era = -1; i_prg = -1;
        while (busy && n < 100000) begin
            if (n == drop_at) supply_ok = 1'b0;
            mark(n);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic s, input logic r, input int drop_at, output int n);
        @(negedge clk);
        store_req = s; recall_req = r;
        @(negedge clk);
        store_req = 1'b0; recall_req = 1'b0;
        count_busy(drop_at, n);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        @(negedge clk);
        d = acc_rdata;
        acc_en = 1'b0;
    endtask

    task automatic check_all(input string rq, input logic [7:0] exp_a [DEPTH]);
        logic [7:0] d;
        for (int a = 0; a < DEPTH; a++) begin
            rd(4'(a), d);
            chk(d == exp_a[a], rq, $sformatf("word %0d", a), int'(d), int'(exp_a[a]));
        end
    endtask

    task automatic fill_work(input int mul, input int add);
        for (int a = 0; a < DEPTH; a++) begin
            work_m[a] = 8'((a * mul + add) % 256);
            wr(4'(a), work_m[a]);
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] d;
        rst = 1'b1; supply_ok = 1'b0; store_req = 1'b0; recall_req = 1'b0;
        acc_en = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
        for (int a = 0; a < DEPTH; a++) shad_m[a] = 8'((37 * a + 11) % 256);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!ready && !busy && !store_err, "R1", "reset state", int'({ready, busy, store_err}), 0);
        repeat (5) @(negedge clk);
        chk(!ready && !busy, "R1", "waits for supply", int'({ready, busy}), 0);

        // R1 power-up recall
        supply_ok = 1'b1;
        @(negedge clk);
        count_busy(-1, n);
        chk(n == RS, "R1", "restore length", n, RS);
        chk(ready == 1'b1, "R1", "ready after restore", int'(ready), 1);
        chk(i_clr >= 0 && i_clr < i_cpy, "R2", "wipe before load", i_clr, i_cpy);
        check_all("R2", shad_m);
        for (int a = 0; a < DEPTH; a++) work_m[a] = shad_m[a];

        // R11 vector table: writes then reads
        for (int v = 0; v < 8; v++) begin
            wr(VEC[v][11:8], VEC[v][7:0]);
            work_m[VEC[v][11:8]] = VEC[v][7:0];
        end
        for (int v = 0; v < 8; v++) begin
            rd(VEC[v][11:8], d);
            chk(d == VEC[v][7:0], "R11", $sformatf("vector %0d", v), int'(d), int'(VEC[v][7:0]));
        end

        // R3 / R10 store
        pulse(1'b1, 1'b0, -1, n);
        chk(n == ST, "R10", "store length", n, ST);
        chk(i_era >= 0 && i_era < i_prg, "R3", "erase before program", i_era, i_prg);
        for (int a = 0; a < DEPTH; a++) shad_m[a] = work_m[a];

        // R2 / R10 recall restores stored data
        fill_work(13, 99);
        pulse(1'b0, 1'b1, -1, n);
        chk(n == RC, "R10", "recall length", n, RC);
        chk(i_clr >= 0 && i_clr < i_cpy, "R2", "wipe before load", i_clr, i_cpy);
        check_all("R3", shad_m);
        for (int a = 0; a < DEPTH; a++) work_m[a] = shad_m[a];

        // R8 / R9 access and commands during busy
        @(negedge clk); store_req = 1'b1;
        @(negedge clk); store_req = 1'b0;
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = 4'd0; acc_wdata = ~work_m[0];
        recall_req = 1'b1;
        @(negedge clk);
        chk(busy && !ready, "R8", "busy during store", int'({busy, ready}), 2);
        recall_req = 1'b0; acc_we = 1'b0;
        @(negedge clk);
        chk(acc_rdata == '0, "R8", "rdata quiet", int'(acc_rdata), 0);
        acc_en = 1'b0;
        count_busy(-1, n);
        repeat (3) begin
            @(negedge clk);
            chk(ready && !busy, "R9", "no queued op", int'({ready, busy}), 2);
        end
        rd(4'd0, d);
        chk(d == work_m[0], "R8", "write ignored", int'(d), int'(work_m[0]));
        for (int a = 0; a < DEPTH; a++) shad_m[a] = work_m[a];

        // R12 simultaneous commands
        pulse(1'b1, 1'b1, -1, n);
        chk(n == RC, "R12", "recall wins", n, RC);

        // R5 abort in program phase
        pulse(1'b1, 1'b0, 14, n);
        chk(n == 15, "R5", "program abort length", n, 15);
        chk(store_err && ready, "R5", "error set", int'({store_err, ready}), 3);
        pulse(1'b0, 1'b1, -1, n);
        for (int a = 0; a < DEPTH; a++) shad_m[a] = 8'hFF;
        check_all("R5", shad_m);

        // R5 abort in erase phase keeps shadow
        fill_work(7, 1);
        @(negedge clk); supply_ok = 1'b1;
        pulse(1'b1, 1'b0, 3, n);
        chk(n == 4 && store_err, "R5", "erase abort", n, 4);
        pulse(1'b0, 1'b1, -1, n);
        check_all("R5", shad_m);

        // R6 successful store clears error
        fill_work(7, 1);
        @(negedge clk); supply_ok = 1'b1;
        pulse(1'b1, 1'b0, -1, n);
        chk(n == ST && !store_err, "R6", "error cleared", int'(store_err), 0);
        for (int a = 0; a < DEPTH; a++) shad_m[a] = work_m[a];

        // R4 store rejected with supply low
        @(negedge clk); supply_ok = 1'b0;
        pulse(1'b1, 1'b0, -1, n);
        chk(n == 0, "R4", "store rejected", n, 0);
        repeat (2) begin
            @(negedge clk);
            chk(!busy && ready, "R4", "stays idle", int'(busy), 0);
        end
        fill_work(5, 200);
        pulse(1'b0, 1'b1, -1, n);
        check_all("R4", shad_m);

        // R7 supply drop during recall
        @(negedge clk); supply_ok = 1'b1;
        pulse(1'b0, 1'b1, 2, n);
        chk(n == RC, "R7", "recall not aborted", n, RC);
        chk(!ready && !busy, "R7", "waits after drop", int'({ready, busy}), 0);
        repeat (4) @(negedge clk);
        chk(!ready, "R7", "still waiting", int'(ready), 0);
        supply_ok = 1'b1;
        @(negedge clk);
        count_busy(-1, n);
        chk(n == RS, "R7", "fresh restore", n, RS);
        check_all("R7", shad_m);

        chk(multi_strobe == 0, "R13", "one strobe at a time", multi_strobe, 0);
        chk(!(wipe_work | load_work | erase_shadow | prog_shadow), "R13", "idle strobes",
            int'({wipe_work, load_work, erase_shadow, prog_shadow}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule